// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a synchronous host and an asynchronous static RAM of 32K bytes. The RAM's chip enable, output enable and write enable are all active low. The host hands over one word operation at a time through a valid/ready handshake that carries a read-or-write flag, a 15-bit address and 8 bits of write data. The block turns each operation into a strobe sequence on the memory pins, and returns read data with a single-cycle valid pulse.

Every analog minimum the RAM needs is set as a nanosecond parameter. The block divides each one by the clock-period parameter and rounds up to whole cycles. Reads hold chip enable and output enable low for the longest of the cycle, address-access and output-enable-access minimums. After a read the block waits out the memory's bus-release window. Only then can a write drive the shared data bus.

Writes raise the address one cycle before write enable falls. They keep the write data on the bus for one cycle after the write ends. As a result, write enable is high on every cycle in which the address changes.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with no request, chip enable, output enable and write enable are high (1), the data-bus enable is low (0), ready is high and read-valid is low.
- R2: A read drives chip enable low, output enable low, write enable high and the data-bus enable low. A write drives chip enable low, write enable low, output enable high and the data-bus enable high. Write enable is never low while chip enable is high.
- R3: A read keeps chip enable and output enable low for RD_CYC cycles, where RD_CYC is the largest of ceil(70 ns/T), ceil(50 ns/T) and the read-cycle count. The data bus is sampled at the end of the last of those cycles. Read-valid is high for exactly one cycle, RD_CYC+1 cycles after acceptance, carrying the sampled byte.
- R4: A write holds chip enable and write enable low together for WR_CYC cycles. WR_CYC is the largest of ceil(70 ns/T) for the cycle, chip-enable and address-valid minimums, ceil(50 ns/T) for the write pulse and ceil(40 ns/T) for data setup. The write data is driven from one cycle before write enable falls until one cycle after the write ends.
- R5: The memory address changes only on cycles where write enable is high both before and after the change.
- R6: After output enable rises at the end of a read, the controller does not drive the data bus for at least TURN_CYC = ceil(30 ns/T) cycles. The data-bus enable is never high while output enable is low.
- R7: A request is accepted on a clock edge where valid and ready are both high. Ready is low from the next cycle until the operation ends: RD_CYC+TURN_CYC cycles for a read, WR_CYC+2 cycles for a write. Requests presented while ready is low are ignored and write nothing.
- R8: A read returns the byte most recently written to the same address, for any addresses across the whole 15-bit range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller idle and able to accept |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 8 | Read data |
| mem_addr | output | 15 | Memory address |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the shared data bus |
| mem_dq_in | input | 8 | Data from the memory |

## Verification
Two events can fall in the same stretch of cycles: the read-valid return and bus-release wait of one read, and the acceptance and bus drive of the next write. The bench provokes this by holding a write request valid while a read is still in progress. This exposes any early drive of the data bus. A timed memory model in the bench flags any data drive that starts less than 30 ns after its own output release. It also flags a write that misses a pulse, overlap or setup minimum, and it returns a corrupted byte if sampled before its access times. The bench then judges the gap in cycles between output enable rising and the data-bus enable rising, and checks both the read data and the later readback of the write.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RD,
    PH_TURN,
    PH_WSET,
    PH_WR,
    PH_WEND
  } phase_e;

  function automatic int ns_to_cycles(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_strobe_fsm.sv
module sram_strobe_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC   = 7,
  parameter int WR_CYC   = 7,
  parameter int TURN_CYC = 3,
  parameter int CNT_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_done,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             req_ready,
  output logic             accept,
  output logic             rd_capture,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             dq_oe
);

  phase_e state_q;
  phase_e state_d;
  logic   ce_n_d;
  logic   oe_n_d;
  logic   we_n_d;
  logic   dq_oe_d;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      PH_IDLE: begin
        if (req_valid) begin
          if (req_write) begin
            state_d = PH_WSET;
          end else begin
            state_d  = PH_RD;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(RD_CYC - 1);
          end
        end
      end
      PH_RD: begin
        if (tmr_done) begin
          state_d  = PH_TURN;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(TURN_CYC - 1);
        end
      end
      PH_TURN: begin
        if (tmr_done) begin
          state_d = PH_IDLE;
        end
      end
      PH_WSET: begin
        state_d  = PH_WR;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(WR_CYC - 1);
      end
      PH_WR: begin
        if (tmr_done) begin
          state_d = PH_WEND;
        end
      end
      PH_WEND: begin
        state_d = PH_IDLE;
      end
      default: begin
        state_d = PH_IDLE;
      end
    endcase
  end

  always_comb begin
    ce_n_d  = !(state_d inside {PH_RD, PH_WSET, PH_WR});
    oe_n_d  = (state_d != PH_RD);
    we_n_d  = (state_d != PH_WR);
    dq_oe_d = (state_d inside {PH_WSET, PH_WR, PH_WEND});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      ce_n    <= 1'b1;
      oe_n    <= 1'b1;
      we_n    <= 1'b1;
      dq_oe   <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_n    <= ce_n_d;
      oe_n    <= oe_n_d;
      we_n    <= we_n_d;
      dq_oe   <= dq_oe_d;
    end
  end

  assign req_ready  = (state_q == PH_IDLE);
  assign accept     = req_ready && req_valid;
  assign rd_capture = (state_q == PH_RD) && tmr_done;

  // Assertion support: length of the current write-enable low run and
  // cycles since output enable last went high.
  logic [CNT_W:0] we_run_q;
  logic [CNT_W:0] oe_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run_q <= '0;
      oe_hi_q  <= (CNT_W+1)'(TURN_CYC);
    end else begin
      we_run_q <= we_n ? '0 : we_run_q + 1'b1;
      if (!oe_n) begin
        oe_hi_q <= '0;
      end else if (oe_hi_q < (CNT_W+1)'(TURN_CYC)) begin
        oe_hi_q <= oe_hi_q + 1'b1;
      end
    end
  end

  assert_we_needs_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ce_n);

  assert_read_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |-> (!ce_n && !oe_n && we_n && !dq_oe));

  assert_we_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (we_run_q >= (CNT_W+1)'(WR_CYC)));

  assert_drive_oe_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);

  assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> (oe_hi_q >= (CNT_W+1)'(TURN_CYC)));

  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

endmodule

// File: rtl/sram_bus_regs.sv
module sram_bus_regs #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              rd_capture,
  input  logic [DATA_W-1:0] mem_dq_in,
  input  logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rvld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_capture) begin
      rdata_q <= mem_dq_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvld_q <= 1'b0;
    end else begin
      rvld_q <= rd_capture;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign rsp_valid  = rvld_q;
  assign rsp_rdata  = rdata_q;

  assert_addr_we_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr_q) |-> (mem_we_n && $past(mem_we_n)));

  assert_rsp_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rvld_q |=> !rvld_q);

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RD_CYCLE_NS = 70,
  parameter int T_ADDR_ACC_NS = 70,
  parameter int T_OE_ACC_NS   = 50,
  parameter int T_WR_CYCLE_NS = 70,
  parameter int T_CE_WR_NS    = 70,
  parameter int T_ADDR_WR_NS  = 70,
  parameter int T_WE_PULSE_NS = 50,
  parameter int T_DSETUP_NS   = 40,
  parameter int T_RELEASE_NS  = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int RD_CYC = max_of(ns_to_cycles(T_RD_CYCLE_NS, CLK_PERIOD_NS),
                                 max_of(ns_to_cycles(T_ADDR_ACC_NS, CLK_PERIOD_NS),
                                        ns_to_cycles(T_OE_ACC_NS, CLK_PERIOD_NS)));
  localparam int WR_CE  = max_of(ns_to_cycles(T_CE_WR_NS, CLK_PERIOD_NS),
                                 ns_to_cycles(T_ADDR_WR_NS, CLK_PERIOD_NS));
  localparam int WR_WE  = max_of(ns_to_cycles(T_WE_PULSE_NS, CLK_PERIOD_NS),
                                 ns_to_cycles(T_DSETUP_NS, CLK_PERIOD_NS));
  localparam int WR_CYC = max_of(max_of(WR_CE, WR_WE),
                                 ns_to_cycles(T_WR_CYCLE_NS, CLK_PERIOD_NS));
  localparam int TURN_CYC = max_of(ns_to_cycles(T_RELEASE_NS, CLK_PERIOD_NS), 1);
  localparam int MAX_CYC  = max_of(max_of(RD_CYC, WR_CYC), TURN_CYC);
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_s1_q;
  logic rst_s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic             rst_int_n;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;
  logic             accept;
  logic             rd_capture;

  assign rst_int_n = rst_s2_q;

  sram_phase_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sram_strobe_fsm #(
    .RD_CYC   (RD_CYC),
    .WR_CYC   (WR_CYC),
    .TURN_CYC (TURN_CYC),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .tmr_done   (tmr_done),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .req_ready  (req_ready),
    .accept     (accept),
    .rd_capture (rd_capture),
    .ce_n       (mem_ce_n),
    .oe_n       (mem_oe_n),
    .we_n       (mem_we_n),
    .dq_oe      (mem_dq_oe)
  );

  sram_bus_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rd_capture (rd_capture),
    .mem_dq_in  (mem_dq_in),
    .mem_we_n   (mem_we_n),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

endmodule

// File: tb/sram_strobe_ctrl_bench.sv
`timescale 1ns / 100ps
module sram_strobe_ctrl_bench;

  localparam int PER  = 8;
  localparam int HALF = PER / 2;
  localparam int RD_CYC   = 9;   // ceil(70/8)
  localparam int WR_CYC   = 9;   // ceil(70/8)
  localparam int TURN_CYC = 4;   // ceil(30/8)
  localparam int NVEC     = 14;

  // {write, address[14:0], data[7:0]}; for reads data is the expected byte
  localparam logic [23:0] VECS [NVEC] = '{
    {1'b1, 15'h0000, 8'hA5}, {1'b1, 15'h7FFF, 8'h5A}, {1'b1, 15'h1234, 8'h3C},
    {1'b0, 15'h0000, 8'hA5}, {1'b0, 15'h7FFF, 8'h5A}, {1'b1, 15'h0000, 8'hFF},
    {1'b0, 15'h1234, 8'h3C}, {1'b0, 15'h0000, 8'hFF}, {1'b1, 15'h4000, 8'h00},
    {1'b0, 15'h4000, 8'h00}, {1'b1, 15'h2AAA, 8'h55}, {1'b0, 15'h2AAA, 8'h55},
    {1'b1, 15'h5555, 8'hAA}, {1'b0, 15'h7FFF, 8'h5A}
  };

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [14:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [14:0] mem_addr;
  logic        mem_ce_n;
  logic        mem_oe_n;
  logic        mem_we_n;
  logic [7:0]  mem_dq_out;
  logic        mem_dq_oe;
  logic [7:0]  mem_dq_in;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  sram_strobe_ctrl #(
    .CLK_PERIOD_NS (PER)
  ) u_sram_strobe_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .mem_dq_in  (mem_dq_in)
  );

  initial clk = 1'b0;
  always #(HALF) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
               req, what, act, act, exp, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // ---------------- timed memory model (sampled at falling edges) ----------
  logic [7:0] store [int];
  int t_ce = -1000, t_oe = -1000, t_we = -1000, t_addr = -1000;
  int t_rel = -1000, t_data = -1000;
  logic [14:0] p_addr = '0;
  logic p_ce = 1'b1, p_oe = 1'b1, p_we = 1'b1, p_dqoe = 1'b0, p_rd = 1'b0;
  logic [7:0] p_dq = '0;

  initial mem_dq_in = 8'h00;

  always @(negedge clk) begin
    int e;
    int nx;
    logic rd_now;
    logic [7:0] val;
    e      = int'($time) - HALF;
    rd_now = !mem_ce_n && !mem_oe_n && mem_we_n;
    if (mem_addr != p_addr) begin
      check(mem_we_n && p_we, "R5", "address changed with write enable low",
            int'(mem_we_n & p_we), 1);
      t_addr = e;
    end
    if (!mem_ce_n && p_ce) t_ce = e;
    if (!mem_oe_n && p_oe) t_oe = e;
    if (!mem_we_n && p_we) t_we = e;
    if (p_rd && !rd_now) t_rel = e;
    if (mem_dq_oe && (!p_dqoe || mem_dq_out != p_dq)) t_data = e;
    if (mem_dq_oe && !p_dqoe)
      check(!rd_now && (e - t_rel >= 30), "R6", "ns from memory release to drive",
            e - t_rel, 30);
    if (mem_dq_oe && rd_now)
      check(1'b0, "R6", "drive during read", 1, 0);
    if (!p_we && !p_ce && (mem_we_n || mem_ce_n)) begin
      check(e - t_we >= 50, "R4", "write pulse ns", e - t_we, 50);
      check(e - t_ce >= 70, "R4", "chip enable to write end ns", e - t_ce, 70);
      check(e - t_addr >= 70, "R4", "address to write end ns", e - t_addr, 70);
      check(p_dqoe && (e - t_data >= 40), "R4", "data setup ns", e - t_data, 40);
      check(mem_dq_oe, "R4", "data held past write end", int'(mem_dq_oe), 1);
      store[int'(p_addr)] = p_dq;
    end
    nx  = e + PER;
    val = store.exists(int'(mem_addr)) ? store[int'(mem_addr)] : 8'h00;
    if (rd_now && (nx - t_ce >= 70) && (nx - t_addr >= 70) && (nx - t_oe >= 50))
      mem_dq_in = val;
    else
      mem_dq_in = ~val;
    p_addr = mem_addr; p_ce = mem_ce_n; p_oe = mem_oe_n; p_we = mem_we_n;
    p_dqoe = mem_dq_oe; p_dq = mem_dq_out; p_rd = rd_now;
  end

  // ---------------- host operation ------------------------------------------
  task automatic do_op(input bit wr, input logic [14:0] a, input logic [7:0] d,
                       input bit intrude, output logic [7:0] rd, output int busy,
                       output int lat, output logic [3:0] strb);
    int k;
    rd = 8'h00; busy = 0; lat = 0; strb = 4'h0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    k = 1;
    while (!req_ready && k < 100) begin
      busy++;
      if (k == 2) strb = {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe};
      if (rsp_valid) begin rd = rsp_rdata; lat = k; end
      if (intrude && k == 3) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0BEE; req_wdata = 8'h99;
      end
      if (intrude && k == 4) req_valid = 1'b0;
      @(negedge clk);
      k++;
    end
  endtask

  logic [7:0] shadow [int];

  initial begin
    logic [7:0] rd;
    int busy, lat;
    logic [3:0] strb;
    int last_oe, first_dq;
    logic [7:0] xr;
    rst_n = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1",
          "strobes during reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready && !rsp_valid,
          "R1", "idle after reset",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready, rsp_valid}, 6'b111010);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      do_op(VECS[i][23], VECS[i][22:8], VECS[i][7:0], 1'b0, rd, busy, lat, strb);
      if (VECS[i][23]) begin
        check(busy == WR_CYC + 2, "R7", "write busy cycles", busy, WR_CYC + 2);
        check(strb == 4'b0101, "R2", "write strobes {ce,oe,we,dq_oe}", strb, 4'b0101);
      end else begin
        check(busy == RD_CYC + TURN_CYC, "R7", "read busy cycles", busy, RD_CYC + TURN_CYC);
        check(strb == 4'b0010, "R2", "read strobes {ce,oe,we,dq_oe}", strb, 4'b0010);
        check(lat == RD_CYC + 1, "R3", "read-valid latency", lat, RD_CYC + 1);
        check(rd == VECS[i][7:0], "R8", "read data", rd, VECS[i][7:0]);
      end
    end

    // R7: a request raised while busy is ignored
    do_op(1'b1, 15'h0BEE, 8'h11, 1'b0, rd, busy, lat, strb);
    do_op(1'b1, 15'h0C00, 8'h22, 1'b1, rd, busy, lat, strb);
    check(busy == WR_CYC + 2, "R7", "busy length with intruding request", busy, WR_CYC + 2);
    do_op(1'b0, 15'h0BEE, 8'h00, 1'b0, rd, busy, lat, strb);
    check(rd == 8'h11, "R7", "intruding write ignored", rd, 8'h11);
    do_op(1'b0, 15'h0C00, 8'h00, 1'b0, rd, busy, lat, strb);
    check(rd == 8'h22, "R8", "accepted write landed", rd, 8'h22);

    // R6: write queued behind a read waits out the release window
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 15'h0BEE;
    @(negedge clk);
    req_write = 1'b1; req_addr = 15'h3333; req_wdata = 8'hC3;
    last_oe = 0; first_dq = -1; xr = 8'h00;
    for (int k = 1; k < 40; k++) begin
      if (!mem_oe_n) last_oe = k;
      if (mem_dq_oe && first_dq < 0) first_dq = k;
      if (rsp_valid) xr = rsp_rdata;
      if (req_valid && req_ready) begin
        @(negedge clk);
        req_valid = 1'b0;
        if (mem_dq_oe && first_dq < 0) first_dq = k + 1;
        if (rsp_valid) xr = rsp_rdata;
        break;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(first_dq - last_oe - 1 >= TURN_CYC, "R6", "cycles from oe high to drive",
          first_dq - last_oe - 1, TURN_CYC);
    check(xr == 8'h11, "R3", "read data before queued write", xr, 8'h11);
    do_op(1'b0, 15'h3333, 8'h00, 1'b0, rd, busy, lat, strb);
    check(rd == 8'hC3, "R8", "queued write data", rd, 8'hC3);

    // R1: reset in the middle of a read
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 15'h1234;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    @(posedge clk);
    #2 rst_n = 1'b0;
    #1 check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready, "R1",
             "outputs after mid-read reset",
             {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready}, 5'b11101);
    repeat (3) @(negedge clk);
    check(!rsp_valid, "R1", "no read-valid during reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    do_op(1'b0, 15'h1234, 8'h00, 1'b0, rd, busy, lat, strb);
    check(rd == 8'h3C, "R8", "read after reset recovery", rd, 8'h3C);

    // R8: random write-then-read integrity
    for (int i = 0; i < 24; i++) begin
      logic [14:0] a;
      logic [7:0] d;
      a = 15'($urandom);
      d = 8'($urandom);
      do_op(1'b1, a, d, 1'b0, rd, busy, lat, strb);
      shadow[int'(a)] = d;
    end
    foreach (shadow[ka]) begin
      do_op(1'b0, 15'(ka), 8'h00, 1'b0, rd, busy, lat, strb);
      check(rd == shadow[ka], "R8", "random readback", rd, shadow[ka]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule